// File: doc/BRIEF.md
# Reset-Gated I2C Memory Target

This block is an I2C target in front of a 256-byte register array. It watches oversampled SCL and SDA lines, finds START and STOP conditions and compares the upper nibble of the device byte against a parameter. It acknowledges only on a match and then serves one of two operations. A write carries a word address and one data byte, and the array is updated when the STOP that follows arrives. A read streams bytes from the internal word address until the master answers with a NACK.

A system supervisor drives the reset-active input. While it is high, the block drops any transfer, releases SDA, ignores START and discards a staged write. A modelled internal write cycle that has already begun is not cut short: the busy flag runs for its full programmed length. While that cycle runs, the block does not acknowledge its device byte. A write-protect input, sampled at STOP, prevents the array update and the write cycle.

Top module: `i2c_guarded_mem`

## Requirements
- R1: A START is SDA falling while SCL is high, and a STOP is SDA rising while SCL is high. Before the first START, and after a STOP, clocked bits get no acknowledge.
- R2: SDA is sampled on SCL rising edges, and the block changes its SDA pull only while SCL is low.
- R3: The block acknowledges the device byte by pulling SDA low during the ninth clock only when bits [7:4] equal parameter DEV_ID (default 4'b1010). On a mismatch it stays released until the next START.
- R4: Bit 0 of the device byte selects the operation: 0 is a write, 1 is a read.
- R5: In a write, the second byte is the word address and the third is the data, and both are acknowledged. A fourth byte is not acknowledged. The array is updated only at the STOP that directly follows.
- R6: A committed write raises wcycle_busy_o for exactly WCYCLE_LEN clock cycles. While busy is high, the device byte is not acknowledged.
- R7: A read returns bytes MSB first, starting at the word address. The address advances after every byte and wraps from 255 to 0. A master NACK (SDA high on the ninth clock) ends the read.
- R8: While sup_reset_i is high, the block abandons the current transfer, releases SDA, ignores START and discards a staged write. A write cycle already running keeps wcycle_busy_o high for its full length.
- R9: When wr_lock_i is high at the STOP, the array keeps its contents and wcycle_busy_o stays low.
- R10: After rst, SDA is released, wcycle_busy_o is low and the bus is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oversampling clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Sampled SCL line |
| sda_i | input | 1 | Sampled SDA line (wired level) |
| sda_pull_o | output | 1 | 1 pulls SDA low |
| sup_reset_i | input | 1 | Supervisor reset active |
| wr_lock_i | input | 1 | Write protect, high blocks array writes |
| wcycle_busy_o | output | 1 | Internal write cycle in progress |

## Verification
The assertions assume that the master changes SDA only while SCL is low, except for deliberate START and STOP edges. They also assume that every SCL low phase lasts longer than the three-cycle input latency, so that the block's own SDA moves settle before SCL rises. The bench holds SCL low and high for eight clocks each. It changes data a quarter period after the falling edge and releases SDA on every ninth clock the block may own. It asserts the supervisor reset only between whole bit periods.

// File: rtl/i2cm_pkg.sv
package i2cm_pkg;

    localparam int BYTE_W = 8;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_RX,
        PH_ACK,
        PH_TX,
        PH_MACK
    } phase_e;

    typedef enum logic [1:0] {
        RX_DEV,
        RX_WORD,
        RX_DATA,
        RX_EXTRA
    } rxk_e;

    typedef struct packed {
        logic start;
        logic stop;
        logic scl_rise;
        logic scl_fall;
        logic scl;
        logic sda;
    } bus_ev_t;

    typedef struct packed {
        logic              valid;
        logic [BYTE_W-1:0] data;
    } stage_t;

    function automatic logic dev_match(input logic [BYTE_W-1:0] b, input logic [3:0] id);
        return b[BYTE_W-1 -: 4] == id;
    endfunction

    function automatic rxk_e next_kind(input rxk_e k);
        case (k)
            RX_DEV:  return RX_WORD;
            RX_WORD: return RX_DATA;
            default: return RX_EXTRA;
        endcase
    endfunction

endpackage

// File: rtl/i2cm_bus_cond.sv
module i2cm_bus_cond
    import i2cm_pkg::*;
#(
    parameter int SYNC = 2
)(
    input  logic    clk,
    input  logic    rst,
    input  logic    scl_i,
    input  logic    sda_i,
    output bus_ev_t ev
);
    logic [SYNC-1:0] scl_sr, sda_sr;
    logic            scl_p, sda_p;
    logic            scl_s, sda_s;

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_sr <= '1;
            sda_sr <= '1;
            scl_p  <= 1'b1;
            sda_p  <= 1'b1;
        end else begin
            scl_sr <= {scl_sr[SYNC-2:0], scl_i};
            sda_sr <= {sda_sr[SYNC-2:0], sda_i};
            scl_p  <= scl_s;
            sda_p  <= sda_s;
        end
    end

    assign scl_s = scl_sr[SYNC-1];
    assign sda_s = sda_sr[SYNC-1];

    always_comb begin
        ev.start    = scl_p & scl_s & sda_p & ~sda_s;
        ev.stop     = scl_p & scl_s & ~sda_p & sda_s;
        ev.scl_rise = ~scl_p & scl_s;
        ev.scl_fall = scl_p & ~scl_s;
        ev.scl      = scl_s;
        ev.sda      = sda_s;
    end

    // R1: START and STOP never fire together
    a_r1_cond_exclusive: assert property (@(posedge clk) disable iff (rst)
        !(ev.start && ev.stop));
endmodule

// File: rtl/i2cm_wcycle.sv
module i2cm_wcycle #(
    parameter int LEN = 500000
)(
    input  logic clk,
    input  logic rst,
    input  logic launch,
    output logic busy
);
    localparam int CW = (LEN > 2) ? $clog2(LEN) : 1;
    localparam logic [CW-1:0] LAST = CW'(LEN - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy <= 1'b0;
            cnt  <= '0;
        end else if (launch && !busy) begin
            busy <= 1'b1;
            cnt  <= LAST;
        end else if (busy) begin
            if (cnt == '0) busy <= 1'b0;
            else           cnt  <= cnt - 1'b1;
        end
    end

    // R6: a new cycle is only requested while idle
    a_r6_launch_when_idle: assert property (@(posedge clk) disable iff (rst)
        launch |-> !busy);
endmodule

// File: rtl/i2cm_store.sv
module i2cm_store #(
    parameter int AW = 8,
    parameter int DW = 8
)(
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] cells [DEPTH];

    always_ff @(posedge clk) begin
        if (we) cells[addr] <= wdata;
    end

    assign rdata = cells[addr];
endmodule

// File: rtl/i2c_guarded_mem.sv
module i2c_guarded_mem
    import i2cm_pkg::*;
#(
    parameter logic [3:0] DEV_ID     = 4'b1010,
    parameter int         WORD_AW    = 8,
    parameter int         WCYCLE_LEN = 500000
)(
    input  logic clk,
    input  logic rst,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_pull_o,
    input  logic sup_reset_i,
    input  logic wr_lock_i,
    output logic wcycle_busy_o
);
    localparam logic [3:0] BITS_IN = 4'd8;

    bus_ev_t             ev;
    phase_e              phase;
    rxk_e                rxk;
    logic [3:0]          bitcnt;
    logic [BYTE_W-1:0]   shreg, txreg, mem_rd;
    logic [WORD_AW-1:0]  ptr;
    logic                rw, mack_low;
    stage_t              stg;
    logic                launch, byte_done, ptr_load, ptr_inc, quiet;

    i2cm_bus_cond #(.SYNC(2)) u_cond (
        .clk(clk), .rst(rst), .scl_i(scl_i), .sda_i(sda_i), .ev(ev)
    );

    i2cm_wcycle #(.LEN(WCYCLE_LEN)) u_wcyc (
        .clk(clk), .rst(rst), .launch(launch), .busy(wcycle_busy_o)
    );

    i2cm_store #(.AW(WORD_AW), .DW(BYTE_W)) u_store (
        .clk(clk), .we(launch), .addr(ptr), .wdata(stg.data), .rdata(mem_rd)
    );

    assign quiet     = ~sup_reset_i & ~ev.start & ~ev.stop;
    assign byte_done = (phase == PH_RX) && ev.scl_fall && (bitcnt == BITS_IN);
    assign ptr_load  = quiet && byte_done && (rxk == RX_WORD);
    assign ptr_inc   = quiet && (phase == PH_MACK) && ev.scl_rise;
    assign launch    = ev.stop & stg.valid & ~sup_reset_i & ~wr_lock_i & ~wcycle_busy_o;

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr <= '0;
        end else if (ptr_load) begin
            ptr <= shreg[WORD_AW-1:0];
        end else if (ptr_inc) begin
            ptr <= ptr + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || sup_reset_i) begin
            phase    <= PH_IDLE;
            rxk      <= RX_DEV;
            bitcnt   <= '0;
            rw       <= 1'b0;
            mack_low <= 1'b0;
            stg      <= '0;
            if (rst) begin
                shreg <= '0;
                txreg <= '0;
            end
        end else if (ev.stop) begin
            phase     <= PH_IDLE;
            stg.valid <= 1'b0;
        end else if (ev.start) begin
            phase     <= PH_RX;
            rxk       <= RX_DEV;
            bitcnt    <= '0;
            stg.valid <= 1'b0;
        end else begin
            case (phase)
                PH_RX: begin
                    if (ev.scl_rise) begin
                        shreg  <= {shreg[BYTE_W-2:0], ev.sda};
                        bitcnt <= bitcnt + 4'd1;
                    end else if (byte_done) begin
                        bitcnt <= '0;
                        case (rxk)
                            RX_DEV: begin
                                if (dev_match(shreg, DEV_ID) && !wcycle_busy_o) begin
                                    rw    <= shreg[0];
                                    phase <= PH_ACK;
                                end else begin
                                    phase <= PH_IDLE;
                                end
                            end
                            RX_WORD: phase <= PH_ACK;
                            RX_DATA: begin
                                stg.valid <= 1'b1;
                                stg.data  <= shreg;
                                phase     <= PH_ACK;
                            end
                            default: phase <= PH_IDLE;
                        endcase
                    end
                end
                PH_ACK: begin
                    if (ev.scl_fall) begin
                        if (rxk == RX_DEV && rw) begin
                            phase  <= PH_TX;
                            txreg  <= mem_rd;
                            bitcnt <= '0;
                        end else begin
                            phase <= PH_RX;
                            rxk   <= next_kind(rxk);
                        end
                    end
                end
                PH_TX: begin
                    if (ev.scl_fall) begin
                        txreg <= {txreg[BYTE_W-2:0], 1'b0};
                        if (bitcnt == BITS_IN - 4'd1) begin
                            bitcnt <= '0;
                            phase  <= PH_MACK;
                        end else begin
                            bitcnt <= bitcnt + 4'd1;
                        end
                    end
                end
                PH_MACK: begin
                    if (ev.scl_rise) begin
                        mack_low <= ~ev.sda;
                    end else if (ev.scl_fall) begin
                        if (mack_low) begin
                            phase <= PH_TX;
                            txreg <= mem_rd;
                        end else begin
                            phase <= PH_IDLE;
                        end
                    end
                end
                default: phase <= PH_IDLE;
            endcase
        end
    end

    assign sda_pull_o = (phase == PH_ACK) || (phase == PH_TX && !txreg[BYTE_W-1]);

    // R1: a STOP leaves the engine idle
    a_r1_stop_idles: assert property (@(posedge clk) disable iff (rst)
        ev.stop |=> phase == PH_IDLE);

    // R2: the pull only moves while the sampled SCL is low
    a_r2_move_in_low: assert property (@(posedge clk) disable iff (rst)
        (sda_pull_o != $past(sda_pull_o)) && !$past(sup_reset_i) |-> !$past(ev.scl));

    // R6: no device acknowledge while the write cycle runs
    a_r6_no_ack_busy: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_ACK && rxk == RX_DEV) |-> !wcycle_busy_o);

    // R8: supervisor reset releases SDA
    a_r8_release_sda: assert property (@(posedge clk) disable iff (rst)
        sup_reset_i |=> !sda_pull_o);

    // R8: no write cycle starts under supervisor reset
    a_r8_no_new_cycle: assert property (@(posedge clk) disable iff (rst)
        sup_reset_i && !wcycle_busy_o |=> !wcycle_busy_o);

    // R9: write protect keeps the write cycle from starting
    a_r9_lock_blocks: assert property (@(posedge clk) disable iff (rst)
        wr_lock_i && !wcycle_busy_o |=> !wcycle_busy_o);
endmodule

// File: tb/i2c_guarded_mem_tb_top.sv
module i2c_guarded_mem_tb_top;
    localparam int WCYC = 300;
    localparam int Q    = 4;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic scl_m = 1'b1;
    logic sda_m = 1'b1;
    logic sup_reset = 1'b0;
    logic wr_lock = 1'b0;
    logic sda_pull, busy, sda_line;

    int n_chk = 0;
    int n_fail = 0;
    int busy_cnt = 0;
    bit done = 1'b0;

    logic [7:0] exp_q[$];
    logic [7:0] got_q[$];
    string      tag_q[$];

    always #5 clk = ~clk;

    assign sda_line = sda_m & ~sda_pull;

    i2c_guarded_mem #(.DEV_ID(4'b1010), .WORD_AW(8), .WCYCLE_LEN(WCYC)) dut_i (
        .clk(clk), .rst(rst), .scl_i(scl_m), .sda_i(sda_line),
        .sda_pull_o(sda_pull), .sup_reset_i(sup_reset),
        .wr_lock_i(wr_lock), .wcycle_busy_o(busy)
    );

    always @(posedge clk) if (busy) busy_cnt++;

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic bus_start();
        sda_m = 1'b1; tick(Q);
        scl_m = 1'b1; tick(2*Q);
        sda_m = 1'b0; tick(2*Q);
        scl_m = 1'b0; tick(Q);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; tick(Q);
        scl_m = 1'b1; tick(2*Q);
        sda_m = 1'b1; tick(2*Q);
    endtask

    task automatic send(input logic [7:0] b, output bit ack);
        for (int i = 7; i >= 0; i--) begin
            sda_m = b[i]; tick(Q);
            scl_m = 1'b1; tick(2*Q);
            scl_m = 1'b0; tick(Q);
        end
        sda_m = 1'b1; tick(Q);
        scl_m = 1'b1; tick(Q);
        ack = ~sda_line;
        tick(Q);
        scl_m = 1'b0; tick(Q);
    endtask

    task automatic recv(input bit mack);
        logic [7:0] b;
        sda_m = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            tick(Q);
            scl_m = 1'b1; tick(Q);
            b[i] = sda_line;
            tick(Q);
            scl_m = 1'b0; tick(Q);
        end
        sda_m = ~mack; tick(Q);
        scl_m = 1'b1; tick(2*Q);
        scl_m = 1'b0; tick(Q);
        sda_m = 1'b1;
        got_q.push_back(b);
    endtask

    task automatic expect_byte(input logic [7:0] v, input string tag);
        exp_q.push_back(v);
        tag_q.push_back(tag);
    endtask

    task automatic wait_free();
        while (busy) tick(1);
        tick(2);
    endtask

    task automatic write1(input logic [7:0] a, input logic [7:0] d, input string tag);
        bit k;
        bus_start();
        send(8'hA0, k); chk(k, {tag, " dev ack"}, k, 1);
        send(a, k);     chk(k, {tag, " word ack"}, k, 1);
        send(d, k);     chk(k, {tag, " data ack"}, k, 1);
        bus_stop();
    endtask

    task automatic read_at(input logic [7:0] a, input int n);
        bit k;
        bus_start();
        send(8'hA0, k); chk(k, "R4 dummy write ack", k, 1);
        send(a, k);     chk(k, "R5 word ack", k, 1);
        bus_start();
        send(8'hA1, k); chk(k, "R4 read dev ack", k, 1);
        for (int i = 0; i < n; i++) recv(i < n - 1);
        bus_stop();
    endtask

    // scoreboard monitor
    initial begin
        forever begin
            @(negedge clk);
            while (got_q.size() > 0 && exp_q.size() > 0) begin
                logic [7:0] g, e;
                string t;
                g = got_q.pop_front();
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                chk(g == e, t, g, e);
            end
        end
    end

    // watchdog
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", 150000, 0);
            $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        bit k;
        tick(4);
        rst = 1'b0;
        tick(4);
        // R10
        chk(sda_pull == 1'b0, "R10 sda released", sda_pull, 0);
        chk(busy == 1'b0, "R10 busy low", busy, 0);

        // R1: no START, no response
        send(8'hA0, k);
        chk(!k, "R1 ignored before START", k, 0);
        sda_m = 1'b1; scl_m = 1'b1; tick(2*Q);

        // R5 / R6: write and busy length
        busy_cnt = 0;
        write1(8'h10, 8'h5A, "R5");
        chk(busy == 1'b1, "R6 busy after STOP", busy, 1);
        bus_start();
        send(8'hA1, k); chk(!k, "R6 no ack while busy", k, 0);
        bus_stop();
        wait_free();
        chk(busy_cnt == WCYC, "R6 busy length", busy_cnt, WCYC);

        // R7 / R4: read back
        read_at(8'h10, 1);
        expect_byte(8'h5A, "R7 read byte");

        // R7: wrap from 255 to 0
        write1(8'hFF, 8'h11, "R5"); wait_free();
        write1(8'h00, 8'h22, "R5"); wait_free();
        write1(8'h01, 8'hC6, "R5"); wait_free();
        read_at(8'hFF, 3);
        expect_byte(8'h11, "R7 seq byte at FF");
        expect_byte(8'h22, "R7 wrap to 00");
        expect_byte(8'hC6, "R7 next byte 01");

        // R3: wrong device ids
        bus_start();
        send(8'h50, k); chk(!k, "R3 id 0101 rejected", k, 0);
        send(8'h10, k); chk(!k, "R3 later bytes ignored", k, 0);
        bus_stop();
        bus_start();
        send(8'hB0, k); chk(!k, "R3 id 1011 rejected", k, 0);
        bus_stop();
        chk(busy == 1'b0, "R3 no write cycle", busy, 0);

        // R5: extra byte gets no ack, first data commits
        bus_start();
        send(8'hA0, k); chk(k, "R5 dev ack", k, 1);
        send(8'h20, k); chk(k, "R5 word ack", k, 1);
        send(8'h33, k); chk(k, "R5 data ack", k, 1);
        send(8'h44, k); chk(!k, "R5 fourth byte nack", k, 0);
        bus_stop();
        wait_free();
        read_at(8'h20, 1);
        expect_byte(8'h33, "R5 first data kept");

        // R9: write protect
        wr_lock = 1'b1;
        write1(8'h20, 8'h77, "R9");
        tick(4);
        chk(busy == 1'b0, "R9 no cycle when locked", busy, 0);
        wr_lock = 1'b0;
        read_at(8'h20, 1);
        expect_byte(8'h33, "R9 array unchanged");

        // R8: abort a write in flight
        write1(8'h30, 8'h66, "R8"); wait_free();
        bus_start();
        send(8'hA0, k); chk(k, "R8 dev ack", k, 1);
        send(8'h30, k); chk(k, "R8 word ack", k, 1);
        sup_reset = 1'b1;
        send(8'h99, k); chk(!k, "R8 no ack in reset", k, 0);
        chk(sda_pull == 1'b0, "R8 sda released", sda_pull, 0);
        bus_stop();
        bus_start();
        send(8'hA0, k); chk(!k, "R8 START ignored in reset", k, 0);
        bus_stop();
        chk(busy == 1'b0, "R8 no cycle from reset", busy, 0);
        sup_reset = 1'b0;
        tick(4);
        read_at(8'h30, 1);
        expect_byte(8'h66, "R8 aborted write discarded");

        // R8: running cycle survives reset
        busy_cnt = 0;
        write1(8'h40, 8'hC3, "R8");
        tick(10);
        sup_reset = 1'b1;
        tick(40);
        chk(busy == 1'b1, "R8 cycle still running", busy, 1);
        wait_free();
        chk(busy_cnt == WCYC, "R8 full cycle length", busy_cnt, WCYC);
        sup_reset = 1'b0;
        tick(4);
        read_at(8'h40, 1);
        expect_byte(8'hC3, "R8 in-flight write completed");

        tick(20);
        chk(exp_q.size() == 0 && got_q.size() == 0, "R7 scoreboard drained",
            got_q.size(), exp_q.size());
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end
endmodule